// File: doc/BRIEF.md
# RV32I Subset Instruction Decoder

This block is the control decoder of a single-cycle core with separate instruction and data memories. It looks at one 32-bit instruction word and, with no clock and no state, drives every control line the datapath needs in the same cycle. These lines are the ALU function, whether ALU operand B is a register or the immediate, the source of the register writeback, the register write enable, the data memory read and write enables with the access width and load extension, and the branch and jump flags with a compare condition.

The instruction set it accepts is a fixed part of RV32I. It covers register and immediate arithmetic, logic and shifts, the word load and the two unsigned narrow loads, the three store widths, the six conditional branches, both jumps, and the two upper-immediate forms. Everything else decodes as illegal. An illegal instruction has every side effect switched off and a flag raised, so the surrounding core can trap or treat it as a bubble.

Top module: `rv_subset_decoder`

## Requirements
- R1: Opcode 0110011 (register–register) sets alu_op_o from funct3 (bits 14:12) and bit 30. The mapping is 000 ADD(0) or SUB(1) when bit 30 is set, 001 SLL(5), 010 SLT(8), 011 SLTU(9), 100 XOR(4), 101 SRL(6) or SRA(7) when bit 30 is set, 110 OR(3) and 111 AND(2). It also drives alu_src_imm_o=0, wb_sel_o=0 (ALU) and reg_we_o=1. The only legal funct7 (bits 31:25) values are 0000000, and 0100000 with funct3 000 or 101.
- R2: Opcode 0010011 (register–immediate) uses the same funct3 mapping, but funct3 000 is always ADD whatever bit 30 holds. It drives alu_src_imm_o=1, wb_sel_o=0 and reg_we_o=1. With funct3 001, funct7 must be 0000000. With funct3 101, funct7 must be 0000000 (SRL) or 0100000 (SRA).
- R3: Opcode 0000011 decodes funct3 010 as word (mem_size_o=2, load_zext_o=0), 100 as unsigned byte (mem_size_o=0, load_zext_o=1) and 101 as unsigned halfword (mem_size_o=1, load_zext_o=1). It drives mem_re_o=1, wb_sel_o=1 (memory), alu_src_imm_o=1, ADD and reg_we_o=1.
- R4: Opcode 0100011 decodes funct3 000, 001 and 010 as byte, halfword and word stores (mem_size_o 0, 1, 2). It drives mem_we_o=1, reg_we_o=0, alu_src_imm_o=1 and ADD.
- R5: Opcode 1100011 drives branch_o=1, reg_we_o=0, alu_src_imm_o=0 and SUB. br_cond_o is {invert, kind[1:0]}, where kind is 0 for equal, 1 for signed less-than and 2 for unsigned less-than. This gives BEQ(000)=0, BNE(001)=4, BLT(100)=1, BGE(101)=5, BLTU(110)=2 and BGEU(111)=6.
- R6: Opcode 1101111 (JAL), and opcode 1100111 with funct3 000 (JALR), drive jump_o=1, wb_sel_o=2 (PC+4), reg_we_o=1, alu_src_imm_o=1 and ADD.
- R7: Opcode 0110111 drives wb_sel_o=3 (immediate), and opcode 0010111 drives wb_sel_o=4 (PC plus immediate). Both drive reg_we_o=1, alu_src_imm_o=1 and ADD.
- R8: An opcode outside the supported set, or an unsupported funct3/funct7 combination, raises illegal_o=1 and drives every other output to 0. Loads with funct3 000 or 001 are such combinations.
- R9: A destination field (bits 11:7) of zero forces reg_we_o to 0 and leaves every other output as it would otherwise be.
- R10: For every legal instruction that is not a branch, br_cond_o is 0. For every legal instruction that is neither a load nor a store, mem_size_o and load_zext_o are 0. mem_re_o and mem_we_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| alu_op_o | output | 4 | ALU function code |
| alu_src_imm_o | output | 1 | ALU operand B is the immediate |
| wb_sel_o | output | 3 | Writeback source: 0 ALU, 1 memory, 2 PC+4, 3 immediate, 4 PC+immediate |
| reg_we_o | output | 1 | Register file write enable |
| mem_re_o | output | 1 | Data memory read enable |
| mem_we_o | output | 1 | Data memory write enable |
| branch_o | output | 1 | Conditional branch |
| jump_o | output | 1 | Unconditional jump |
| br_cond_o | output | 3 | Branch compare: {invert, kind} |
| mem_size_o | output | 2 | Access width: 0 byte, 1 halfword, 2 word |
| load_zext_o | output | 1 | Loaded value is zero-extended |
| illegal_o | output | 1 | Instruction is outside the supported set |

## Verification
The checker assumes only that the instruction input has a defined value whenever it is evaluated. The bench drives a known word before the first evaluation point and changes the input only on a rising edge. Apart from that, the assertions take any 32-bit word as valid stimulus. The stimulus therefore sweeps every major opcode, every funct3 of each supported opcode and the edge funct7 values exhaustively, and then runs a long pseudo-random stream whose low seven bits are mostly forced to supported opcodes so that the decode paths are well hit.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
  localparam int ILEN  = 32;
  localparam int OPC_W = 7;
  localparam int F3_W  = 3;
  localparam int F7_W  = 7;
  localparam int RD_W  = 5;

  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR  = 4'd3,
    ALU_XOR = 4'd4, ALU_SLL = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
    ALU_SLT = 4'd8, ALU_SLTU = 4'd9
  } alu_op_e;

  typedef enum logic [2:0] {
    WB_ALU = 3'd0, WB_MEM = 3'd1, WB_PC4 = 3'd2, WB_IMM = 3'd3, WB_PCIMM = 3'd4
  } wb_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2
  } mem_size_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0, CMP_LTS = 2'd1, CMP_LTU = 2'd2
  } cmp_kind_e;

  typedef enum logic [3:0] {
    CL_NONE, CL_OP, CL_OPIMM, CL_LOAD, CL_STORE,
    CL_BRANCH, CL_JAL, CL_JALR, CL_LUI, CL_AUIPC
  } op_class_e;
endpackage

// File: rtl/rvdec_opclass.sv
module rvdec_opclass
  import rvdec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output op_class_e        class_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_OP:     class_o = CL_OP;
      OPC_OPIMM:  class_o = CL_OPIMM;
      OPC_LOAD:   class_o = CL_LOAD;
      OPC_STORE:  class_o = CL_STORE;
      OPC_BRANCH: class_o = CL_BRANCH;
      OPC_JAL:    class_o = CL_JAL;
      OPC_JALR:   class_o = CL_JALR;
      OPC_LUI:    class_o = CL_LUI;
      OPC_AUIPC:  class_o = CL_AUIPC;
      default:    class_o = CL_NONE;
    endcase
  end
endmodule

// File: rtl/rvdec_alu_ctrl.sv
module rvdec_alu_ctrl
  import rvdec_pkg::*;
(
  input  op_class_e       class_i,
  input  logic [F3_W-1:0] funct3_i,
  input  logic [F7_W-1:0] funct7_i,
  output alu_op_e         alu_op_o,
  output logic            legal_o
);
  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  function automatic alu_op_e map_f3(input logic [F3_W-1:0] f3, input logic alt);
    unique case (f3)
      3'd0:    map_f3 = alt ? ALU_SUB : ALU_ADD;
      3'd1:    map_f3 = ALU_SLL;
      3'd2:    map_f3 = ALU_SLT;
      3'd3:    map_f3 = ALU_SLTU;
      3'd4:    map_f3 = ALU_XOR;
      3'd5:    map_f3 = alt ? ALU_SRA : ALU_SRL;
      3'd6:    map_f3 = ALU_OR;
      default: map_f3 = ALU_AND;
    endcase
  endfunction

  logic alt_ok;
  assign alt_ok = (funct3_i == 3'd0) || (funct3_i == 3'd5);

  always_comb begin
    alu_op_o = ALU_ADD;
    legal_o  = 1'b1;
    unique case (class_i)
      CL_OP: begin
        if (funct7_i == F7_BASE)              alu_op_o = map_f3(funct3_i, 1'b0);
        else if (funct7_i == F7_ALT && alt_ok) alu_op_o = map_f3(funct3_i, 1'b1);
        else                                  legal_o  = 1'b0;
      end
      CL_OPIMM: begin
        // immediate form: bit 30 only meaningful for right shifts
        if (funct3_i == 3'd1)      legal_o = (funct7_i == F7_BASE);
        else if (funct3_i == 3'd5) legal_o = (funct7_i == F7_BASE) || (funct7_i == F7_ALT);
        alu_op_o = map_f3(funct3_i, (funct3_i == 3'd5) && funct7_i[5]);
      end
      CL_BRANCH: alu_op_o = ALU_SUB;
      default:   alu_op_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/rvdec_mem_br.sv
module rvdec_mem_br
  import rvdec_pkg::*;
(
  input  op_class_e       class_i,
  input  logic [F3_W-1:0] funct3_i,
  output mem_size_e       size_o,
  output logic            zext_o,
  output logic [2:0]      br_cond_o,
  output logic            legal_o
);
  cmp_kind_e kind;
  assign kind = !funct3_i[2] ? CMP_EQ : (funct3_i[1] ? CMP_LTU : CMP_LTS);

  always_comb begin
    size_o    = SZ_BYTE;
    zext_o    = 1'b0;
    br_cond_o = '0;
    legal_o   = 1'b1;
    unique case (class_i)
      CL_LOAD: begin
        unique case (funct3_i)
          3'b010:  size_o = SZ_WORD;
          3'b100:  zext_o = 1'b1;
          3'b101:  begin size_o = SZ_HALF; zext_o = 1'b1; end
          default: legal_o = 1'b0;
        endcase
      end
      CL_STORE: begin
        unique case (funct3_i)
          3'b000:  size_o = SZ_BYTE;
          3'b001:  size_o = SZ_HALF;
          3'b010:  size_o = SZ_WORD;
          default: legal_o = 1'b0;
        endcase
      end
      CL_BRANCH: begin
        if (funct3_i[2:1] == 2'b01) legal_o = 1'b0;
        else br_cond_o = {funct3_i[0], kind};
      end
      CL_JALR: legal_o = (funct3_i == 3'd0);
      default: ;
    endcase
  end
endmodule

// File: rtl/rv_subset_decoder.sv
module rv_subset_decoder
  import rvdec_pkg::*;
#(
  parameter int IW = ILEN
) (
  input  logic [IW-1:0] instr_i,
  output logic [3:0]    alu_op_o,
  output logic          alu_src_imm_o,
  output logic [2:0]    wb_sel_o,
  output logic          reg_we_o,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic          branch_o,
  output logic          jump_o,
  output logic [2:0]    br_cond_o,
  output logic [1:0]    mem_size_o,
  output logic          load_zext_o,
  output logic          illegal_o
);
  localparam int RD_LSB = OPC_W;
  localparam int F3_LSB = 12;
  localparam int F7_LSB = IW - F7_W;

  logic [OPC_W-1:0] opcode;
  logic [F3_W-1:0]  funct3;
  logic [F7_W-1:0]  funct7;
  logic [RD_W-1:0]  rd;
  logic             unused_fields;

  assign opcode        = instr_i[OPC_W-1:0];
  assign rd            = instr_i[RD_LSB +: RD_W];
  assign funct3        = instr_i[F3_LSB +: F3_W];
  assign funct7        = instr_i[F7_LSB +: F7_W];
  assign unused_fields = ^instr_i[F7_LSB-1:F3_LSB+F3_W];

  op_class_e cls;
  alu_op_e   alu_op;
  mem_size_e msize;
  logic      alu_legal, mb_legal, zext;
  logic [2:0] cond;

  rvdec_opclass u_cls (.opcode_i(opcode), .class_o(cls));

  rvdec_alu_ctrl u_alu (
    .class_i(cls), .funct3_i(funct3), .funct7_i(funct7),
    .alu_op_o(alu_op), .legal_o(alu_legal)
  );

  rvdec_mem_br u_mb (
    .class_i(cls), .funct3_i(funct3),
    .size_o(msize), .zext_o(zext), .br_cond_o(cond), .legal_o(mb_legal)
  );

  logic    legal;
  logic    src_imm, we, re, wr, br, jmp;
  wb_sel_e wb;

  assign legal = (cls != CL_NONE) && alu_legal && mb_legal;

  always_comb begin
    src_imm = 1'b1;
    wb      = WB_ALU;
    we      = 1'b1;
    re      = 1'b0;
    wr      = 1'b0;
    br      = 1'b0;
    jmp     = 1'b0;
    unique case (cls)
      CL_OP:     src_imm = 1'b0;
      CL_OPIMM:  ;
      CL_LOAD:   begin wb = WB_MEM; re = 1'b1; end
      CL_STORE:  begin we = 1'b0; wr = 1'b1; end
      CL_BRANCH: begin src_imm = 1'b0; we = 1'b0; br = 1'b1; end
      CL_JAL,
      CL_JALR:   begin wb = WB_PC4; jmp = 1'b1; end
      CL_LUI:    wb = WB_IMM;
      CL_AUIPC:  wb = WB_PCIMM;
      default:   begin src_imm = 1'b0; we = 1'b0; end
    endcase
  end

  // single gating point: an illegal word leaves every output at zero
  assign illegal_o     = !legal;
  assign alu_op_o      = legal ? alu_op : ALU_ADD;
  assign alu_src_imm_o = legal & src_imm;
  assign wb_sel_o      = legal ? wb : WB_ALU;
  assign reg_we_o      = legal & we & (rd != '0);
  assign mem_re_o      = legal & re;
  assign mem_we_o      = legal & wr;
  assign branch_o      = legal & br;
  assign jump_o        = legal & jmp;
  assign br_cond_o     = legal ? cond : 3'd0;
  assign mem_size_o    = legal ? msize : SZ_BYTE;
  assign load_zext_o   = legal & zext;
endmodule

// File: rtl/rv_subset_decoder_chk.sv
module rv_subset_decoder_chk (
  input logic [31:0] instr_i,
  input logic [3:0]  alu_op_o,
  input logic        alu_src_imm_o,
  input logic [2:0]  wb_sel_o,
  input logic        reg_we_o,
  input logic        mem_re_o,
  input logic        mem_we_o,
  input logic        branch_o,
  input logic        jump_o,
  input logic [2:0]  br_cond_o,
  input logic [1:0]  mem_size_o,
  input logic        load_zext_o,
  input logic        illegal_o
);
  always_comb begin
    a_r8_illegal_quiet: assert (!illegal_o ||
      !(reg_we_o || mem_re_o || mem_we_o || branch_o || jump_o))
      else $error("R8 illegal word has side effect");
    a_r9_rd0_no_write: assert (instr_i[11:7] != 5'd0 || !reg_we_o)
      else $error("R9 write to x0 enabled");
    a_r10_mem_excl: assert (!(mem_re_o && mem_we_o))
      else $error("R10 read and write together");
    a_r4_store_no_wb: assert (!mem_we_o || (!reg_we_o && alu_src_imm_o))
      else $error("R4 store controls wrong");
    a_r5_branch_only: assert (!branch_o || (!jump_o && !reg_we_o && !mem_re_o && !mem_we_o))
      else $error("R5 branch controls wrong");
    a_r3_zext_narrow: assert (!load_zext_o || (mem_re_o && mem_size_o != 2'd2))
      else $error("R3 zero-extension on non-narrow load");
    a_r1_alu_range: assert (alu_op_o <= 4'd9)
      else $error("R1 ALU code out of range");
    a_r6_jump_pc4: assert (!jump_o || (wb_sel_o == 3'd2))
      else $error("R6 jump writeback select wrong");
    a_r10_cond_branch: assert (br_cond_o == 3'd0 || branch_o)
      else $error("R10 condition without branch");
  end
endmodule

bind rv_subset_decoder rv_subset_decoder_chk u_chk (.*);

// File: tb/tb_rv_subset_decoder.sv
module tb_rv_subset_decoder;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr = 32'd0;
  logic [3:0] alu_op;
  logic [2:0] wb_sel, br_cond;
  logic [1:0] mem_size;
  logic src_imm, reg_we, mem_re, mem_we, branch, jump, zext, illegal;

  rv_subset_decoder dut (
    .instr_i(instr), .alu_op_o(alu_op), .alu_src_imm_o(src_imm), .wb_sel_o(wb_sel),
    .reg_we_o(reg_we), .mem_re_o(mem_re), .mem_we_o(mem_we), .branch_o(branch),
    .jump_o(jump), .br_cond_o(br_cond), .mem_size_o(mem_size),
    .load_zext_o(zext), .illegal_o(illegal)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [3:0] amap(input int f3, input bit alt);
    case (f3)
      0: return alt ? 4'd1 : 4'd0;
      1: return 4'd5;
      2: return 4'd8;
      3: return 4'd9;
      4: return 4'd4;
      5: return alt ? 4'd7 : 4'd6;
      6: return 4'd3;
      default: return 4'd2;
    endcase
  endfunction

  // packed: {alu4, src, wb3, we, re, mwe, br, jmp, cond3, size2, zext, ill}
  function automatic logic [19:0] ref_dec(input logic [31:0] w);
    int op = int'(w[6:0]);
    int f3 = int'(w[14:12]);
    int f7 = int'(w[31:25]);
    bit ill = 0, src = 0, we = 0, re = 0, mwe = 0, br = 0, jmp = 0, zx = 0;
    logic [3:0] a = 0;
    logic [2:0] wb = 0, cnd = 0;
    logic [1:0] sz = 0;
    case (op)
      'h33: begin
        we = 1;
        if (f7 == 0) a = amap(f3, 0);
        else if (f7 == 'h20 && (f3 == 0 || f3 == 5)) a = amap(f3, 1);
        else ill = 1;
      end
      'h13: begin
        we = 1; src = 1;
        if (f3 == 1 && f7 != 0) ill = 1;
        if (f3 == 5 && f7 != 0 && f7 != 'h20) ill = 1;
        a = amap(f3, f3 == 5 && f7 == 'h20);
      end
      'h03: begin
        we = 1; src = 1; re = 1; wb = 1;
        if (f3 == 2) sz = 2;
        else if (f3 == 4) begin sz = 0; zx = 1; end
        else if (f3 == 5) begin sz = 1; zx = 1; end
        else ill = 1;
      end
      'h23: begin
        src = 1; mwe = 1;
        if (f3 <= 2) sz = 2'(f3); else ill = 1;
      end
      'h63: begin
        br = 1; a = 1;
        case (f3)
          0: cnd = 0; 1: cnd = 4; 4: cnd = 1; 5: cnd = 5; 6: cnd = 2; 7: cnd = 6;
          default: ill = 1;
        endcase
      end
      'h6f: begin we = 1; src = 1; jmp = 1; wb = 2; end
      'h67: begin we = 1; src = 1; jmp = 1; wb = 2; if (f3 != 0) ill = 1; end
      'h37: begin we = 1; src = 1; wb = 3; end
      'h17: begin we = 1; src = 1; wb = 4; end
      default: ill = 1;
    endcase
    if (ill) return 20'd1;
    if (w[11:7] == 0) we = 0;
    return {a, src, wb, we, re, mwe, br, jmp, cnd, sz, zx, 1'b0};
  endfunction

  function automatic logic [19:0] got();
    return {alu_op, src_imm, wb_sel, reg_we, mem_re, mem_we, branch, jump,
            br_cond, mem_size, zext, illegal};
  endfunction

  task automatic check(input logic [31:0] w, input string req);
    logic [19:0] exp_v;
    @(posedge clk);
    instr = w;
    @(negedge clk);
    exp_v = ref_dec(w);
    total++;
    if (got() !== exp_v) begin
      bad++;
      $display("FAIL %s instr=%h actual=%h expected=%h", req, w, got(), exp_v);
    end
  endtask

  function automatic logic [31:0] enc(input int f7, input int f3, input int rd, input int op);
    return {7'(f7), 5'd7, 5'd9, 3'(f3), 5'(rd), 7'(op)};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int f7s[3] = '{0, 'h20, 'h01};
    int ops[10] = '{'h33, 'h13, 'h03, 'h23, 'h63, 'h6f, 'h67, 'h37, 'h17, 'h0b};
    // reset state: all-zero word is illegal, all outputs zero
    @(negedge clk);
    total++;
    if (got() !== 20'd1) begin
      bad++;
      $display("FAIL R8 reset-state actual=%h expected=%h", got(), 20'd1);
    end
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    for (int f3 = 0; f3 < 8; f3++)
      for (int k = 0; k < 3; k++) check(enc(f7s[k], f3, 5, 'h33), "R1");
    for (int f3 = 0; f3 < 8; f3++)
      for (int k = 0; k < 3; k++) check(enc(f7s[k], f3, 6, 'h13), "R2");
    check(enc('h7f, 0, 6, 'h13), "R2");
    for (int f3 = 0; f3 < 8; f3++) check(enc(0, f3, 4, 'h03), "R3");
    for (int f3 = 0; f3 < 8; f3++) check(enc(0, f3, 4, 'h23), "R4");
    for (int f3 = 0; f3 < 8; f3++) check(enc(0, f3, 0, 'h63), "R5");
    check(enc('h55, 3, 1, 'h6f), "R6");
    for (int f3 = 0; f3 < 8; f3++) check(enc(0, f3, 1, 'h67), "R6");
    check(enc('h12, 5, 10, 'h37), "R7");
    check(enc('h33, 2, 11, 'h17), "R7");
    for (int op = 0; op < 128; op++) check(enc(0, 0, 3, op), "R8");
    check(enc(0, 0, 8, 'h03), "R8");
    check(enc(0, 1, 8, 'h03), "R8");
    for (int k = 0; k < 9; k++) check(enc(0, 2, 0, ops[k]), "R9");
    check(enc('h20, 0, 0, 'h33), "R9");
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w;
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      w = rng;
      if (rng[31:28] < 4'd10) w[6:0] = 7'(ops[rng[31:28]]);
      check(w, "R10");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule